// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block arbitrates interrupt requests from seven sources on behalf of a CPU: one timer source shared by all timers, two DMA channels and four external lines. Requests arrive already captured, as one pending level per source. Each source carries its own 3-bit priority and a mask bit. The block picks the most urgent request that is unmasked, that clears the global priority threshold, and that is more urgent than every source already in service. It raises an interrupt line whenever such a request exists.

The CPU takes a request in one of two ways. It can pulse the acknowledge input, or it can read the poll register. Either one marks the winning source as in service. Software ends service with an end-of-interrupt write. That write either names a vector or asks the block to retire the most urgent in-service source. A poll-status read shows the same winner but has no side effect. All state sits behind a small register bus: a synchronous write, and a combinational read of the selected register.

Top module: `pic_ctrl`

## Requirements
- R1: Priority 0 is the most urgent and 7 the least. Among eligible requests the lowest priority number wins. On equal priority the lower vector wins.
- R2: Vectors are 8 + slot. Slot 0 is the timer (vector 8), slot 2 is DMA0 (10), slot 3 is DMA1 (11) and slots 4 to 7 are INT0 to INT3 (12 to 15). The mask, in-service and request registers use the slot as the bit index. Slot 1 does not exist: its input is ignored and its bits read 0.
- R3: A pending request is eligible only if its priority number is strictly below that of every source currently in service.
- R4: A cycle with `inta_i` high and an eligible request sets that source's in-service bit. During that cycle `vec_o` shows the winner's vector, and it shows 0 when no request is eligible.
- R5: A read of address 1 (poll) returns the request flag in bit 15 and the winning vector in bits 4:0, and sets the winner's in-service bit. A read of address 2 (poll status) returns the same word and changes nothing. With no eligible request the whole word is 0.
- R6: In the threshold register (address 4, bits 2:0), a source is eligible only if its priority number is at most the stored code. The register resets to 7.
- R7: Each source's mask bit appears both in the mask register (address 3, bit = slot) and in bit 3 of that source's control register (address 8 + slot, priority in bits 2:0). Writing the bit through either path is visible through the other. A masked source is never eligible.
- R8: A write to address 0 with bit 15 clear clears the in-service bit of the vector in bits 4:0. Vectors outside 8 to 15, and vector 9, change nothing.
- R9: A write to address 0 with bit 15 set clears the in-service bit of the most urgent in-service source, chosen by the rule of R1.
- R10: Reset clears every in-service bit, sets every mask bit, sets every priority to 7 and holds `irq_o` low.
- R11: `irq_o` is high exactly when some request is eligible. It follows the inputs and the state without a register stage.
- R12: A read of address 6 returns the pending inputs of the existing slots. The in-service register reads at address 5, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a poll read has a side effect) |
| addr | input | 4 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of the addressed register |
| src_pend_i | input | 8 | Captured pending request per slot |
| inta_i | input | 1 | Interrupt acknowledge pulse |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | 5 | Vector of the current winner |

## Verification
The hardest situation to reach is a stack of several in-service sources at different priorities. It is needed to see strict nested blocking and the choice made by a non-specific end-of-interrupt. A single acknowledge gives only one level. The bench first drives a directed nesting sequence: it acknowledges a source, raises a less urgent one that stays blocked, then promotes a source past it. After that comes a long pseudo-random sweep. The sweep mixes priority rewrites, mask changes through both paths, threshold changes, acknowledges, polls and both kinds of end-of-interrupt. A bench-side model predicts every read and the interrupt output.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int NSLOT = 8;
    localparam int SW    = $clog2(NSLOT);
    localparam int PW    = 3;
    localparam int VW    = 5;
    localparam int DW    = 16;
    localparam int AW    = 4;
    localparam int VBASE = 8;

    localparam logic [NSLOT-1:0] SLOT_USED = 8'b1111_1101;

    localparam logic [AW-1:0] A_EOI    = 4'd0;
    localparam logic [AW-1:0] A_POLL   = 4'd1;
    localparam logic [AW-1:0] A_PSTAT  = 4'd2;
    localparam logic [AW-1:0] A_MASK   = 4'd3;
    localparam logic [AW-1:0] A_THRESH = 4'd4;
    localparam logic [AW-1:0] A_INSERV = 4'd5;
    localparam logic [AW-1:0] A_REQ    = 4'd6;

    localparam int EOI_NSPEC_BIT = 15;
    localparam int CTL_MSK_BIT   = 3;

    typedef logic [PW-1:0] prio_t;

    typedef struct packed {
        logic            hit;
        logic [SW-1:0]   idx;
        prio_t           prio;
    } pick_t;

    function automatic logic [VW-1:0] slot_to_vec(logic [SW-1:0] s);
        return VW'(VBASE) + VW'(s);
    endfunction

    function automatic logic [AW-1:0] ctl_addr(int s);
        return AW'(VBASE + s);
    endfunction
endpackage

// File: rtl/pic_pick.sv
module pic_pick
    import pic_pkg::*;
#(
    parameter int N = NSLOT
) (
    input  logic [N-1:0]         cand,
    input  logic [N-1:0][PW-1:0] prio,
    output pick_t                pick
);
    always_comb begin
        pick = '{hit: 1'b0, idx: '0, prio: '1};
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!pick.hit || prio[i] < pick.prio)) begin
                pick.hit  = 1'b1;
                pick.idx  = SW'(i);
                pick.prio = prio[i];
            end
        end
    end
endmodule

// File: rtl/pic_cfg.sv
module pic_cfg
    import pic_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [AW-1:0]            addr,
    input  logic [DW-1:0]            wdata,
    output logic [NSLOT-1:0]         msk_o,
    output logic [NSLOT-1:0][PW-1:0] pri_o,
    output prio_t                    thresh_o
);
    prio_t thresh_q;

    always_ff @(posedge clk) begin
        if (rst)
            thresh_q <= '1;
        else if (wr_en && addr == A_THRESH)
            thresh_q <= wdata[PW-1:0];
    end
    assign thresh_o = thresh_q;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        if (SLOT_USED[s]) begin : g_used
            logic  m_q;
            prio_t p_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    m_q <= 1'b1;
                    p_q <= '1;
                end else if (wr_en && addr == A_MASK) begin
                    m_q <= wdata[s];
                end else if (wr_en && addr == ctl_addr(s)) begin
                    m_q <= wdata[CTL_MSK_BIT];
                    p_q <= wdata[PW-1:0];
                end
            end
            assign msk_o[s] = m_q;
            assign pri_o[s] = p_q;
        end else begin : g_hole
            assign msk_o[s] = 1'b1;
            assign pri_o[s] = '1;
        end
    end
endmodule

// File: rtl/pic_inserv.sv
module pic_inserv
    import pic_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic [SW-1:0]    set_idx,
    input  logic             clr_en,
    input  logic [SW-1:0]    clr_idx,
    output logic [NSLOT-1:0] is_o
);
    logic [NSLOT-1:0] is_q;
    logic [NSLOT-1:0] set_vec, clr_vec;

    always_comb begin
        set_vec = '0;
        clr_vec = '0;
        if (set_en) set_vec[set_idx] = 1'b1;
        if (clr_en) clr_vec[clr_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) is_q <= '0;
        else     is_q <= ((is_q & ~clr_vec) | set_vec) & SLOT_USED;
    end
    assign is_o = is_q;

    // R8 / R9: a retired source is no longer in service unless re-taken in the same cycle
    assert_eoi_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !(set_en && set_idx == clr_idx)) |=> !is_q[$past(clr_idx)]);

    // R2: the missing slot never holds an in-service bit
    assert_hole_clear_R2: assert property (@(posedge clk) disable iff (rst)
        !is_q[1]);
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
    import pic_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [3:0]    addr,
    input  logic [15:0]   wdata,
    output logic [15:0]   rdata,
    input  logic [7:0]    src_pend_i,
    input  logic          inta_i,
    output logic          irq_o,
    output logic [4:0]    vec_o
);
    logic [NSLOT-1:0]         msk;
    logic [NSLOT-1:0][PW-1:0] pri;
    prio_t                    thresh;
    logic [NSLOT-1:0]         is_bits;
    logic [NSLOT-1:0]         cand;
    pick_t                    req_pick, is_pick;
    logic [VW-1:0]            req_vec;

    pic_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .msk_o    (msk),
        .pri_o    (pri),
        .thresh_o (thresh)
    );

    // most urgent in-service source: sets the nesting ceiling and the non-specific target
    pic_pick #(.N(NSLOT)) u_is_pick (
        .cand (is_bits),
        .prio (pri),
        .pick (is_pick)
    );

    for (genvar s = 0; s < NSLOT; s++) begin : g_elig
        assign cand[s] = SLOT_USED[s] && src_pend_i[s] && !msk[s]
                      && (pri[s] <= thresh)
                      && (!is_pick.hit || pri[s] < is_pick.prio);
    end

    pic_pick #(.N(NSLOT)) u_req_pick (
        .cand (cand),
        .prio (pri),
        .pick (req_pick)
    );

    assign req_vec = slot_to_vec(req_pick.idx);

    // in-service update
    logic          take;
    logic          eoi_wr, eoi_nspec, spec_ok, clr_en;
    logic [VW-1:0] eoi_vec;
    logic [SW-1:0] clr_idx;

    assign take      = req_pick.hit && (inta_i || (rd_en && addr == A_POLL));
    assign eoi_wr    = wr_en && addr == A_EOI;
    assign eoi_nspec = wdata[EOI_NSPEC_BIT];
    assign eoi_vec   = wdata[VW-1:0];
    assign spec_ok   = (eoi_vec >= VW'(VBASE)) && (eoi_vec < VW'(VBASE + NSLOT))
                    && SLOT_USED[eoi_vec[SW-1:0]];
    assign clr_en    = eoi_wr && (eoi_nspec ? is_pick.hit : spec_ok);
    assign clr_idx   = eoi_nspec ? is_pick.idx : eoi_vec[SW-1:0];

    pic_inserv u_inserv (
        .clk     (clk),
        .rst     (rst),
        .set_en  (take),
        .set_idx (req_pick.idx),
        .clr_en  (clr_en),
        .clr_idx (clr_idx),
        .is_o    (is_bits)
    );

    // read mux
    logic [DW-1:0] poll_word;
    assign poll_word = {req_pick.hit, {(DW-1-VW){1'b0}},
                        (req_pick.hit ? req_vec : {VW{1'b0}})};

    always_comb begin
        rdata = '0;
        if (addr[AW-1]) begin
            if (SLOT_USED[addr[SW-1:0]])
                rdata = DW'({msk[addr[SW-1:0]], pri[addr[SW-1:0]]});
        end else begin
            case (addr)
                A_POLL, A_PSTAT: rdata = poll_word;
                A_MASK:          rdata = DW'(msk & SLOT_USED);
                A_THRESH:        rdata = DW'(thresh);
                A_INSERV:        rdata = DW'(is_bits);
                A_REQ:           rdata = DW'(src_pend_i & SLOT_USED);
                default:         rdata = '0;
            endcase
        end
    end

    assign irq_o = req_pick.hit;
    assign vec_o = req_pick.hit ? req_vec : '0;

    // R4 / R5: a taken request is in service on the next cycle
    assert_take_sets_is_R4: assert property (@(posedge clk) disable iff (rst)
        (take && !clr_en) |=> is_bits[$past(req_pick.idx)]);

    // R5: a poll-status read leaves the in-service bits alone
    assert_pstat_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == A_PSTAT && !inta_i && !wr_en) |=> $stable(is_bits));

    // R6: the winner always clears the threshold
    assert_thresh_R6: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> pri[req_pick.idx] <= thresh);

    // R7: a masked source never wins
    assert_mask_R7: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> !msk[req_pick.idx]);

    // R3: the winner is strictly more urgent than every in-service source
    assert_nest_R3: assert property (@(posedge clk) disable iff (rst)
        (irq_o && is_pick.hit) |-> pri[req_pick.idx] < is_pick.prio);

    // R10: first cycle out of reset has no interrupt
    assert_reset_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !irq_o && is_bits == '0);
endmodule

// File: tb/pic_ctrl_tb.sv
`timescale 1ns/1ps
module pic_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0, inta_i = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [7:0]  pend_v = '0;
    logic        irq_o;
    logic [4:0]  vec_o;

    int checks = 0, errors = 0;
    int pri_m[8];
    bit msk_m[8];
    bit is_m[8];
    int thr_m;
    logic [31:0] rs = 32'h1234_5677;

    always #2 clk = ~clk;

    pic_ctrl u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .src_pend_i(pend_v), .inta_i(inta_i),
        .irq_o(irq_o), .vec_o(vec_o)
    );

    function automatic logic [31:0] rnd();
        rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
        return rs;
    endfunction

    function automatic bit used(int s);
        return s != 1;
    endfunction

    function automatic int win();
        int ceil_p = 8, best = -1;
        for (int s = 0; s < 8; s++)
            if (used(s) && is_m[s] && pri_m[s] < ceil_p) ceil_p = pri_m[s];
        for (int s = 0; s < 8; s++)
            if (used(s) && pend_v[s] && !msk_m[s] && pri_m[s] <= thr_m && pri_m[s] < ceil_p
                && (best < 0 || pri_m[s] < pri_m[best])) best = s;
        return best;
    endfunction

    function automatic int top_is();
        int best = -1;
        for (int s = 0; s < 8; s++)
            if (used(s) && is_m[s] && (best < 0 || pri_m[s] < pri_m[best])) best = s;
        return best;
    endfunction

    function automatic logic [15:0] poll_exp();
        int w = win();
        return (w < 0) ? 16'h0 : (16'h8000 | 16'(8 + w));
    endfunction

    function automatic logic [15:0] is_exp();
        logic [15:0] v = '0;
        for (int s = 0; s < 8; s++) v[s] = is_m[s];
        return v;
    endfunction

    function automatic logic [15:0] mask_exp();
        logic [15:0] v = '0;
        for (int s = 0; s < 8; s++) v[s] = used(s) && msk_m[s];
        return v;
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic rd(logic [3:0] a, output logic [15:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a; #1 d = rdata;
        @(negedge clk); rd_en = 1'b0; addr = '0;
    endtask

    task automatic check_state();
        logic [15:0] d;
        int w;
        #1;
        w = win();
        check("R11 irq", 16'(irq_o), 16'(w >= 0));
        check("R1 vec", 16'(vec_o), (w < 0) ? 16'h0 : 16'(8 + w));
        rd(4'd5, d);
        check("R3 in-service", d, is_exp());
    endtask

    task automatic set_ctl(int s, int msk, int p);
        wr(4'(8 + s), 16'((msk << 3) | p));
        if (used(s)) begin msk_m[s] = msk[0]; pri_m[s] = p; end
    endtask

    task automatic do_ack();
        int w;
        @(negedge clk); inta_i = 1'b1; #1;
        w = win();
        check("R4 ack vec", 16'(vec_o), (w < 0) ? 16'h0 : 16'(8 + w));
        @(negedge clk); inta_i = 1'b0;
        if (w >= 0) is_m[w] = 1'b1;
    endtask

    task automatic do_poll(bit side);
        logic [15:0] d, e;
        int w = win();
        e = poll_exp();
        rd(side ? 4'd1 : 4'd2, d);
        check(side ? "R5 poll" : "R5 poll-status", d, e);
        if (side && w >= 0) is_m[w] = 1'b1;
    endtask

    task automatic do_eoi(bit nspec, int v);
        int t = top_is();
        wr(4'd0, nspec ? 16'h8000 : 16'(v));
        if (nspec) begin
            if (t >= 0) is_m[t] = 1'b0;
        end else if (v >= 8 && v <= 15 && used(v - 8)) begin
            is_m[v - 8] = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] d;
        for (int s = 0; s < 8; s++) begin pri_m[s] = 7; msk_m[s] = 1; is_m[s] = 0; end
        thr_m = 7;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R10 reset state
        check("R10 irq after reset", 16'(irq_o), 16'h0);
        rd(4'd3, d);  check("R10 mask reset", d, 16'h00FD);
        rd(4'd4, d);  check("R6 threshold reset", d, 16'h0007);
        rd(4'd5, d);  check("R10 in-service reset", d, 16'h0000);
        rd(4'd12, d); check("R10 ctl reset", d, 16'h000F);
        rd(4'd9, d);  check("R2 hole ctl", d, 16'h0000);
        rd(4'd7, d);  check("R12 unmapped", d, 16'h0000);

        // R1 tie: timer and INT0 at the same level, timer (8) wins
        pend_v = 8'b0001_0011;
        set_ctl(0, 0, 2);
        set_ctl(4, 0, 2);
        check_state();
        rd(4'd6, d); check("R2 R12 request bits", d, 16'h0011);
        // R1 more urgent INT0 overtakes
        set_ctl(4, 0, 1);
        check_state();
        do_ack();
        check_state();  // R3: timer at level 2 blocked by INT0 in service
        // R2 DMA0 at vector 10 is more urgent and gets through the nesting
        pend_v[2] = 1'b1;
        set_ctl(2, 0, 0);
        check_state();
        do_poll(1'b1);
        check_state();
        // R8 specific EOI for vector 10, then R9 non-specific for INT0
        do_eoi(1'b0, 10);
        check_state();
        do_eoi(1'b1, 0);
        check_state();
        // R6 threshold blocks levels above 0
        wr(4'd4, 16'h0000); thr_m = 0;
        check_state();
        wr(4'd4, 16'h0007); thr_m = 7;
        // R7 mask register path shows in control register
        wr(4'd3, 16'h0004); for (int s = 0; s < 8; s++) if (used(s)) msk_m[s] = (s == 2);
        rd(4'd10, d); check("R7 mask via ctl", d, 16'(8 | pri_m[2]));
        check_state();

        // pseudo-random sweep
        for (int it = 0; it < 1500; it++) begin
            logic [31:0] r = rnd();
            int op = int'(r[3:0]) % 10;
            case (op)
                0: begin
                    int s = int'(r[6:4]);
                    set_ctl(s, (r[9:7] == 0) ? 1 : 0, int'(r[12:10]));
                    rd(4'(8 + s), d);
                    check("R7 ctl readback", d, used(s) ? 16'((msk_m[s] << 3) | pri_m[s]) : 16'h0);
                    rd(4'd3, d); check("R7 mask readback", d, mask_exp());
                end
                1: begin
                    logic [15:0] m = 16'(r[23:16] & rnd());
                    int s = int'(r[6:4]);
                    wr(4'd3, m);
                    for (int k = 0; k < 8; k++) if (used(k)) msk_m[k] = m[k];
                    rd(4'(8 + s), d);
                    check("R7 ctl mask bit", 16'(d[3]), used(s) ? 16'(msk_m[s]) : 16'h0);
                end
                2: begin
                    thr_m = (r[5:4] == 0) ? int'(r[8:6]) : 7;
                    wr(4'd4, 16'(r[31:16] & 16'hFFF8) | 16'(thr_m));
                    rd(4'd4, d); check("R6 threshold readback", d, 16'(thr_m));
                end
                3: begin
                    @(negedge clk); pend_v = r[23:16];
                    rd(4'd6, d); check("R12 request", d, 16'(pend_v & 8'hFD));
                end
                4: do_ack();
                5: do_poll(1'b1);
                6: do_poll(1'b0);
                7: do_eoi(1'b0, r[4] ? int'(r[12:8]) : 8 + int'(r[7:5]));
                8: do_eoi(1'b1, 0);
                default: begin
                    int s = int'(r[6:4]);
                    if (used(s)) set_ctl(s, 0, int'(r[9:7]));
                    @(negedge clk); pend_v = pend_v | r[23:16];
                end
            endcase
            check_state();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule